// File: doc/BRIEF.md
# Clock Divider, Reset Filter and Standby Controller

This block sits between a raw oscillator and a small controller core. It turns the oscillator clock into a clock enable for the core, thinned by a statically selected ratio of one, three or four. It also filters an active-low external reset pin into a clean synchronous reset, so that a glitch on the pin cannot reset the core. Finally, it parks the core in a low-power standby when the core executes a halt, and lets a wake pin end that standby.

The external reset pin is sampled through a two-stage synchronizer. A run of four consecutive low samples raises the internal reset. Release waits for the pin to read high and for a clock-enable slot, so the core always sees the release on one of its own clock boundaries. The halt request from the core is taken on an enabled cycle. From then on the enable to the core is held low, while the divider and the wake logic keep running on the raw clock. A wake sample taken on the same edge as the halt is discarded, so chatter during the halt cycle cannot cancel the halt. A separate power-on input gives all flops their asynchronous initial state.

Top module: `clk_rst_stby`

## Requirements
- R1: With div_sel_i = 00, clk_en_o is high in every cycle. With 01, clk_en_o is a one-cycle pulse every 3 clocks. With 10 or 11, it is a one-cycle pulse every 4 clocks. These hold while the block is not in standby.
- R2: Let the rising edge at which rst_pin_n_i is first sampled low be edge 1. If the pin stays low for at least four consecutive edges, sys_rst_o goes high after edge 6: two synchronizer stages, then the fourth low sample.
- R3: A low pulse on rst_pin_n_i that covers fewer than four consecutive rising edges leaves sys_rst_o low.
- R4: sys_rst_o falls only at an edge that closes a cycle in which clk_en_o was high. This happens once the synchronized pin reads high.
- R5: A halt is accepted at an edge where halt_i, clk_en_o and a low sys_rst_o coincide. From that edge on, standby_o is high and clk_en_o is low.
- R6: A low level on wake_n_i sampled at the edge that accepts the halt does not end standby.
- R7: A low level on wake_n_i sampled at any later edge Ea clears standby_o at edge Ea+1. After that, clk_en_o resumes its divided pattern.
- R8: While por_n_i is low, sys_rst_o is high and standby_o is low.
- R9: An accepted external reset clears standby, even when wake_n_i stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Raw oscillator clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| div_sel_i | input | 2 | Static ratio select: 00 = /1, 01 = /3, 10 or 11 = /4 |
| rst_pin_n_i | input | 1 | External reset pin, active low, asynchronous |
| halt_i | input | 1 | Halt request from the core, taken on an enabled cycle |
| wake_n_i | input | 1 | Wake pin, active low, ends standby |
| clk_en_o | output | 1 | Divided clock enable for the core |
| sys_rst_o | output | 1 | Filtered synchronous reset, active high |
| standby_o | output | 1 | High while the core is parked in standby |

## Verification
The divider is run in each of the four select codes, and the spacing of the enables is measured. This catches a wrong modulus, a missing wrap, and a code that falls to the wrong ratio.

Reset pulses of random length from one to seven clocks show where the filter threshold lies. The cycle on which the reset rises, and the enable phase at which it falls, are also checked.

Halts are issued in three ways: with the wake pin low only in the halt cycle, with the wake pin held low throughout, and with a random wake delay. Together these separate the blocked halt-cycle sample from a real wake, and pin down the one-cycle wake latency. A reset issued during standby shows that reset alone can leave standby.

// File: rtl/ckd_pkg.sv
package ckd_pkg;
  typedef enum logic [1:0] {
    DIV_BY1 = 2'b00,
    DIV_BY3 = 2'b01,
    DIV_BY4 = 2'b10
  } div_sel_e;
endpackage

// File: rtl/ckd_divider.sv
module ckd_divider #(
  parameter int DIV_MID  = 3,
  parameter int DIV_SLOW = 4
) (
  input  logic       clk_i,
  input  logic       por_n_i,
  input  logic [1:0] div_sel_i,
  output logic       tick_o
);
  import ckd_pkg::*;

  localparam int MAXD = (DIV_MID > DIV_SLOW) ? DIV_MID : DIV_SLOW;
  localparam int CW   = (MAXD > 1) ? $clog2(MAXD) : 1;

  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    case (div_sel_i)
      DIV_BY1: lim = '0;
      DIV_BY3: lim = CW'(DIV_MID - 1);
      default: lim = CW'(DIV_SLOW - 1);
    endcase
    cnt_d  = (cnt_q >= lim) ? '0 : cnt_q + 1'b1;
    tick_o = (cnt_q == '0);
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end

  AST_DIV_NO_BACK2BACK: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (tick_o && div_sel_i != DIV_BY1) |=> (!tick_o || !$stable(div_sel_i))); // R1
  AST_DIV1_ALWAYS: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (div_sel_i == DIV_BY1 && $stable(div_sel_i)) |-> tick_o); // R1
endmodule

// File: rtl/ckd_reset_filter.sv
module ckd_reset_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 4
) (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic rst_pin_n_i,
  input  logic tick_i,
  output logic rst_o
);
  localparam int CNT_W = (MIN_LOW > 1) ? $clog2(MIN_LOW) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MIN_LOW - 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [CNT_W-1:0]       low_cnt_q, low_cnt_d;
  logic                   rst_q, rst_d;
  logic                   sync_low;

  always_comb begin
    sync_d   = {sync_q[SYNC_STAGES-2:0], rst_pin_n_i};
    sync_low = ~sync_q[SYNC_STAGES-1];
    if (!sync_low)              low_cnt_d = '0;
    else if (low_cnt_q == CNT_TOP) low_cnt_d = low_cnt_q;
    else                        low_cnt_d = low_cnt_q + 1'b1;
    rst_d = rst_q;
    if (sync_low && low_cnt_q == CNT_TOP) rst_d = 1'b1;
    else if (!sync_low && tick_i)         rst_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      sync_q    <= '1;
      low_cnt_q <= '0;
      rst_q     <= 1'b1;
    end else begin
      sync_q    <= sync_d;
      low_cnt_q <= low_cnt_d;
      rst_q     <= rst_d;
    end
  end

  assign rst_o = rst_q;

  AST_RST_AFTER_LOW_RUN: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $rose(rst_q) |-> ($past(sync_low) && $past(low_cnt_q) == CNT_TOP)); // R2
  AST_RST_RELEASE_ON_TICK: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $fell(rst_q) |-> $past(tick_i)); // R4
endmodule

// File: rtl/ckd_standby.sv
module ckd_standby (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic sys_rst_i,
  input  logic tick_i,
  input  logic halt_i,
  input  logic wake_n_i,
  output logic clk_en_o,
  output logic standby_o
);
  logic stby_q, stby_d;
  logic armed_q, armed_d;
  logic wake_q;
  logic accept;

  always_comb begin
    clk_en_o = tick_i & ~stby_q;
    accept   = halt_i & clk_en_o & ~sys_rst_i;
    stby_d   = stby_q;
    armed_d  = armed_q;
    if (sys_rst_i) begin
      stby_d  = 1'b0;
      armed_d = 1'b0;
    end else if (accept) begin
      stby_d  = 1'b1;
      armed_d = 1'b0;
    end else if (stby_q) begin
      armed_d = 1'b1;
      if (armed_q && !wake_q) begin
        stby_d  = 1'b0;
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      stby_q  <= 1'b0;
      armed_q <= 1'b0;
      wake_q  <= 1'b1;
    end else begin
      stby_q  <= stby_d;
      armed_q <= armed_d;
      wake_q  <= wake_n_i;
    end
  end

  assign standby_o = stby_q;

  AST_HALT_ENTERS: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (halt_i && clk_en_o && !sys_rst_i) |=> stby_q); // R5
  AST_WAKE_BLOCKED: assert property (@(posedge clk_i) disable iff (!por_n_i)
    ($rose(stby_q) && !sys_rst_i) |=> stby_q); // R6
  AST_EXIT_NEEDS_CAUSE: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $fell(stby_q) |-> ($past(sys_rst_i) || !$past(wake_q))); // R7
endmodule

// File: rtl/clk_rst_stby.sv
module clk_rst_stby #(
  parameter int DIV_MID     = 3,
  parameter int DIV_SLOW    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 4
) (
  input  logic       clk_i,
  input  logic       por_n_i,
  input  logic [1:0] div_sel_i,
  input  logic       rst_pin_n_i,
  input  logic       halt_i,
  input  logic       wake_n_i,
  output logic       clk_en_o,
  output logic       sys_rst_o,
  output logic       standby_o
);
  logic tick;

  ckd_divider #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_div (
    .clk_i     (clk_i),
    .por_n_i   (por_n_i),
    .div_sel_i (div_sel_i),
    .tick_o    (tick)
  );

  ckd_reset_filter #(.SYNC_STAGES(SYNC_STAGES), .MIN_LOW(MIN_LOW)) u_rst (
    .clk_i       (clk_i),
    .por_n_i     (por_n_i),
    .rst_pin_n_i (rst_pin_n_i),
    .tick_i      (tick),
    .rst_o       (sys_rst_o)
  );

  ckd_standby u_stby (
    .clk_i     (clk_i),
    .por_n_i   (por_n_i),
    .sys_rst_i (sys_rst_o),
    .tick_i    (tick),
    .halt_i    (halt_i),
    .wake_n_i  (wake_n_i),
    .clk_en_o  (clk_en_o),
    .standby_o (standby_o)
  );

  AST_RST_CLEARS_STBY: assert property (@(posedge clk_i) disable iff (!por_n_i)
    sys_rst_o |=> !standby_o); // R9
endmodule

// File: tb/clk_rst_stby_test.sv
module clk_rst_stby_test;
  logic       clk = 1'b0;
  logic       por_n;
  logic [1:0] div_sel;
  logic       rst_pin_n, halt, wake_n;
  logic       clk_en, sys_rst, standby;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  clk_rst_stby uut (
    .clk_i(clk), .por_n_i(por_n), .div_sel_i(div_sel), .rst_pin_n_i(rst_pin_n),
    .halt_i(halt), .wake_n_i(wake_n), .clk_en_o(clk_en), .sys_rst_o(sys_rst),
    .standby_o(standby)
  );

  function automatic int exp_gap(logic [1:0] s);
    case (s)
      2'b00:   return 1;
      2'b01:   return 3;
      default: return 4;
    endcase
  endfunction

  function automatic int exp_rise(int len);
    return (len >= 4) ? 6 : 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic run_divider(logic [1:0] s);
    int last = -1, bad = 0, highs = 0;
    div_sel = s;
    repeat (8) step();
    for (int i = 0; i < 24; i++) begin
      step();
      if (clk_en) begin
        highs++;
        if (last >= 0 && (i - last) != exp_gap(s)) bad++;
        last = i;
      end
    end
    check(bad == 0, "R1 gap", bad, 0);
    check(highs == 24 / exp_gap(s), "R1 count", highs, 24 / exp_gap(s));
  endtask

  task automatic reset_pulse(int len);
    int rise_at = 0, fall_at = 0;
    bit prev_en = clk_en;
    bit prev_rst = sys_rst;
    bit misaligned = 0;
    for (int i = 0; i < 24; i++) begin
      rst_pin_n = (i < len) ? 1'b0 : 1'b1;
      step();
      if (sys_rst && !prev_rst && rise_at == 0) rise_at = i + 1;
      if (!sys_rst && prev_rst) begin
        fall_at = i + 1;
        if (!prev_en) misaligned = 1;
      end
      prev_en = clk_en;
      prev_rst = sys_rst;
    end
    if (len >= 4) check(rise_at == exp_rise(len), "R2 rise cycle", rise_at, exp_rise(len));
    else          check(rise_at == 0, "R3 short pulse ignored", rise_at, 0);
    if (len >= 4) begin
      check(fall_at != 0, "R4 release seen", fall_at, 1);
      check(!misaligned, "R4 release on enable", int'(misaligned), 0);
    end
    check(sys_rst == 1'b0, "R4 reset released", int'(sys_rst), 0);
  endtask

  task automatic wait_enable();
    for (int i = 0; i < 8; i++) begin
      if (clk_en) break;
      step();
    end
  endtask

  task automatic halt_blocked_wake(int delay);
    int bad = 0;
    wait_enable();
    halt = 1'b1; wake_n = 1'b0;
    step();
    halt = 1'b0; wake_n = 1'b1;
    check(standby == 1'b1, "R5 standby entered", int'(standby), 1);
    for (int i = 0; i < 10 + delay; i++) begin
      step();
      if (!standby || clk_en) bad++;
    end
    check(bad == 0, "R6 halt-cycle wake ignored, R5 enable held low", bad, 0);
    wake_n = 1'b0;
    step();
    check(standby == 1'b1, "R7 one cycle wake latency", int'(standby), 1);
    step();
    wake_n = 1'b1;
    check(standby == 1'b0, "R7 standby cleared", int'(standby), 0);
    bad = 1;
    for (int i = 0; i < 5; i++) begin
      step();
      if (clk_en) bad = 0;
    end
    check(bad == 0, "R7 enable resumes", bad, 0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    por_n = 1'b0; div_sel = 2'b00; rst_pin_n = 1'b1; halt = 1'b0; wake_n = 1'b1;
    repeat (3) step();
    check(sys_rst == 1'b1, "R8 reset during power-on", int'(sys_rst), 1);
    check(standby == 1'b0, "R8 standby low during power-on", int'(standby), 0);
    por_n = 1'b1;
    repeat (6) step();
    check(sys_rst == 1'b0, "R4 release after power-on", int'(sys_rst), 0);

    for (int s = 0; s < 4; s++) run_divider(2'(s));

    reset_pulse(3);
    reset_pulse(4);
    for (int k = 0; k < 10; k++) begin
      div_sel = 2'($urandom_range(0, 3));
      reset_pulse($urandom_range(1, 7));
    end

    for (int s = 0; s < 3; s++) begin
      div_sel = 2'(s);
      repeat (4) step();
      halt_blocked_wake($urandom_range(0, 9));
    end

    div_sel = 2'b01;
    repeat (4) step();
    wait_enable();
    halt = 1'b1; wake_n = 1'b0;
    step();
    halt = 1'b0;
    check(standby == 1'b1, "R6 held-low wake, after halt edge", int'(standby), 1);
    step();
    check(standby == 1'b1, "R6 held-low wake, arming edge", int'(standby), 1);
    step();
    check(standby == 1'b0, "R7 held-low wake exits", int'(standby), 0);
    wake_n = 1'b1;

    div_sel = 2'b10;
    repeat (4) step();
    wait_enable();
    halt = 1'b1;
    step();
    halt = 1'b0;
    check(standby == 1'b1, "R9 standby before reset", int'(standby), 1);
    reset_pulse(4);
    check(standby == 1'b0, "R9 reset clears standby", int'(standby), 0);

    wait_enable();
    rst_pin_n = 1'b0;
    repeat (8) step();
    halt = 1'b1;
    repeat (8) step();
    halt = 1'b0;
    check(standby == 1'b0, "R5 halt ignored in reset", int'(standby), 0);
    rst_pin_n = 1'b1;
    repeat (8) step();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule